// File: doc/BRIEF.md
# Two/Three-Clock Slave Bus Controller

This block sits between a host bus and the inside of a peripheral. A host reaches byte-wide internal registers and a 16-bit receive/transmit FIFO data path through it. Two select inputs open a cycle. The register select uses a 5-bit address to pick an internal location. The FIFO-direct select ignores the address and goes straight to the receive FIFO on reads or the transmit FIFO on writes. If both selects are seen active together, the cycle is dropped.

Each cycle is timed in one of two ways. A cycle-length input, read only when the cycle opens, chooses either a short access of two clocks or a long access of three clocks with one wait clock. Read data and a data-valid strobe are driven from the first active clock and are settled by the final clock. Writes are captured in the final clock and turned into a one-clock strobe toward the register file or the transmit FIFO. A configuration input picks the bus half that carries register bytes. A board pull-up on the cycle-length input gives the short access by default.

Everything is sampled on the rising clock edge. The register storage and the FIFOs are outside the block and are reached through plain ports.

Top module: `slave_bus_ctrl`

## Requirements
- R1: While idle, a rising edge that sees exactly one of `csN`/`fdsN` low opens a cycle. At that edge it latches `rdWr` (1 = read), `byteEn` and `addr`, and `regAddr` shows the latched address from the next clock on.
- R2: A rising edge in idle that sees both `csN` and `fdsN` low opens no cycle. No `dataValid`, `rxPop`, `txPush` or `regWrEn` follows.
- R3: With `cycleLenSel` high at the opening edge, a read holds `dataValid` for exactly 2 clocks. With it low, a read holds `dataValid` for exactly 3 clocks. A change of `cycleLenSel` after the opening edge has no effect on the cycle already running.
- R4: `dataValid` is high only during the active clocks of a read and falls when the cycle returns to idle. `rdData` is zero whenever `dataValid` is low.
- R5: A register read returns `regRdData` on `rdData[7:0]` with the upper byte zero when `swapBytes` is 0. It returns `regRdData` on `rdData[15:8]` with the lower byte zero when `swapBytes` is 1.
- R6: A read through `fdsN` (any address), or through `csN` at the receive location (address 0), returns `rxData`. With `byteEn` 2'b01 the low byte of `rxData` appears on both halves. With 2'b10 the high byte appears on both halves. With 2'b11 or 2'b00 the full word is returned.
- R7: A receive read raises `rxPop` for exactly one clock, the final clock of the cycle.
- R8: A register write (via `csN` at an address other than 0 and 1) pulses `regWrEn` for one clock, in the clock after the final clock. `regWrData` carries `wrData[7:0]` when `swapBytes` is 0 and `wrData[15:8]` when it is 1, and `regAddr` still shows the written address.
- R9: A write through `fdsN` (any address), or through `csN` at the transmit location (address 1), pulses `txPush` for one clock, in the clock after the final clock. `txData` equals `wrData` and `txByteEn` equals the latched `byteEn`.
- R10: A write through `csN` to the receive location (address 0) produces no `regWrEn`, `txPush` or `rxPop`.
- R11: Cycles may follow back to back, with one idle clock between them, and each cycle uses its own `cycleLenSel` value.
- R12: After reset, `dataValid`, `rdData`, `rxPop`, `txPush` and `regWrEn` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every sample is on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| csN | input | 1 | Register-address select, active low |
| fdsN | input | 1 | FIFO-direct select, active low |
| rdWr | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Register address, used with `csN` only |
| byteEn | input | 2 | Byte lane enables, bit 1 = upper lane |
| cycleLenSel | input | 1 | 1 = two-clock access, 0 = three-clock access |
| swapBytes | input | 1 | 0 = register bytes on the lower half, 1 = upper half |
| wrData | input | 16 | Write data from the host |
| rdData | output | 16 | Read data to the host |
| dataValid | output | 1 | Read data valid |
| regAddr | output | 5 | Latched register address |
| regRdData | input | 8 | Register file read byte for `regAddr` |
| regWrEn | output | 1 | One-clock register write strobe |
| regWrData | output | 8 | Register write byte |
| rxData | input | 16 | Head entry of the receive FIFO |
| rxPop | output | 1 | Receive FIFO pop request |
| txPush | output | 1 | Transmit FIFO push request |
| txData | output | 16 | Transmit FIFO write word |
| txByteEn | output | 2 | Active byte lanes of the pushed word |

## Verification
Reads are run at both cycle lengths, so the count of valid clocks tells the two-clock path apart from the wait-state path. A mid-cycle flip of the length input shows that only the opening edge matters. Receive reads use each byte-enable pattern through both selects, which separates word return from lane duplication and shows that the address is ignored in FIFO-direct mode. Register reads and writes are repeated with both lane settings to expose a swapped or missing lane. Both selects low together, and a register-select write to the receive location, must leave no event in the scoreboard, so any stray strobe shows up as a mismatch.

// File: rtl/slvbus_pkg.sv
package slvbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_S1   = 2'd1,
    ST_WAIT = 2'd2,
    ST_S2   = 2'd3
  } busState_t;

  // strobes passed from the control sequencer to the datapath
  typedef struct packed {
    logic accept;   // opening edge of a cycle is being taken
    logic active;   // cycle is in S1, wait or S2
    logic last;     // final clock of the cycle
  } busStrobe_t;

endpackage

// File: rtl/slvbus_ctrl.sv
module slvbus_ctrl
  import slvbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       fdsN,
  input  logic       cycleLenSel,
  output busStrobe_t strb
);

  busState_t state;
  busState_t stateNext;
  logic      shortQ;
  logic      oneSel;

  // exactly one select low opens a cycle; both low cancels it
  assign oneSel = csN ^ fdsN;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (oneSel) stateNext = ST_S1;
      ST_S1:   stateNext = shortQ ? ST_S2 : ST_WAIT;
      ST_WAIT: stateNext = ST_S2;
      ST_S2:   stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      shortQ <= 1'b1;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && oneSel) shortQ <= cycleLenSel;
    end
  end

  always_comb begin
    strb.accept = (state == ST_IDLE) && oneSel;
    strb.active = (state != ST_IDLE);
    strb.last   = (state == ST_S2);
  end

endmodule

// File: rtl/slvbus_datapath.sv
module slvbus_datapath
  import slvbus_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  parameter int RX_LOC = 0,
  parameter int TX_LOC = 1,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strb,
  input  logic              fdsN,
  input  logic              rdWr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byteEn,
  input  logic              swapBytes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              dataValid,
  output logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxPop,
  output logic              txPush,
  output logic [DATA_W-1:0] txData,
  output logic [LANES-1:0]  txByteEn
);

  localparam logic [ADDR_W-1:0] RX_ADDR = ADDR_W'(RX_LOC);
  localparam logic [ADDR_W-1:0] TX_ADDR = ADDR_W'(TX_LOC);

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  beQ;
  logic              readQ;
  logic              directQ;

  logic rxSel, txSel, regWrSel, singleByte;
  logic [$clog2(LANES)-1:0] pickLane;
  logic [BYTE_W-1:0] pickedByte;
  logic [BYTE_W-1:0] wrByte;
  logic [DATA_W-1:0] regWord, rxWord;

  // latch the cycle attributes at the opening edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      beQ     <= '0;
      readQ   <= 1'b0;
      directQ <= 1'b0;
    end else if (strb.accept) begin
      addrQ   <= addr;
      beQ     <= byteEn;
      readQ   <= rdWr;
      directQ <= ~fdsN;
    end
  end

  // target decode
  assign rxSel    = readQ  && (directQ || addrQ == RX_ADDR);
  assign txSel    = !readQ && (directQ || addrQ == TX_ADDR);
  assign regWrSel = !readQ && !directQ && addrQ != RX_ADDR && addrQ != TX_ADDR;

  // a single enabled lane means a byte transfer
  assign singleByte = $onehot(beQ);
  always_comb begin
    pickLane = '0;
    for (int l = 0; l < LANES; l++) begin
      if (beQ[l]) pickLane = l[$clog2(LANES)-1:0];
    end
  end
  assign pickedByte = rxData[pickLane*BYTE_W +: BYTE_W];
  assign wrByte     = wrData[swapBytes*BYTE_W +: BYTE_W];

  // per-lane placement of register byte and receive data
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign regWord[g*BYTE_W +: BYTE_W] =
      (int'(swapBytes) == g) ? regRdData : '0;
    assign rxWord[g*BYTE_W +: BYTE_W] =
      singleByte ? pickedByte : rxData[g*BYTE_W +: BYTE_W];
  end

  assign dataValid = strb.active && readQ;
  assign rdData    = !dataValid ? '0 : (rxSel ? rxWord : regWord);
  assign rxPop     = strb.last && rxSel;
  assign regAddr   = addrQ;

  // write capture at the final clock, strobe in the following clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      regWrData <= '0;
      txPush    <= 1'b0;
      txData    <= '0;
      txByteEn  <= '0;
    end else begin
      regWrEn <= strb.last && regWrSel;
      txPush  <= strb.last && txSel;
      if (strb.last && regWrSel) regWrData <= wrByte;
      if (strb.last && txSel) begin
        txData   <= wrData;
        txByteEn <= beQ;
      end
    end
  end

endmodule

// File: rtl/slave_bus_ctrl.sv
module slave_bus_ctrl
  import slvbus_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BYTE_W = 8,
  parameter int RX_LOC = 0,
  parameter int TX_LOC = 1,
  localparam int LANES  = 2,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              fdsN,
  input  logic              rdWr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byteEn,
  input  logic              cycleLenSel,
  input  logic              swapBytes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              dataValid,
  output logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxPop,
  output logic              txPush,
  output logic [DATA_W-1:0] txData,
  output logic [LANES-1:0]  txByteEn
);

  busStrobe_t strb;

  slvbus_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .csN         (csN),
    .fdsN        (fdsN),
    .cycleLenSel (cycleLenSel),
    .strb        (strb)
  );

  slvbus_datapath #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .LANES  (LANES),
    .RX_LOC (RX_LOC),
    .TX_LOC (TX_LOC)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fdsN      (fdsN),
    .rdWr      (rdWr),
    .addr      (addr),
    .byteEn    (byteEn),
    .swapBytes (swapBytes),
    .wrData    (wrData),
    .rdData    (rdData),
    .dataValid (dataValid),
    .regAddr   (regAddr),
    .regRdData (regRdData),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .rxData    (rxData),
    .rxPop     (rxPop),
    .txPush    (txPush),
    .txData    (txData),
    .txByteEn  (txByteEn)
  );

endmodule

// File: rtl/slvbus_checker.sv
module slvbus_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic fdsN,
  input logic cycleLenSel,
  input logic busy,
  input logic last,
  input logic dataValid,
  input logic rxPop,
  input logic txPush,
  input logic regWrEn
);

  a_r1_open_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (csN ^ fdsN)) |=> busy);

  a_r2_both_cancel: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !csN && !fdsN) |=> (!busy && !dataValid));

  a_r3_short_len: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && $past(cycleLenSel)) |-> ##1 last);

  a_r3_long_len: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !$past(cycleLenSel)) |-> ##1 (!last) ##1 last);

  a_r4_valid_in_cycle: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> busy);

  a_r4_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    last |=> (!busy && !dataValid));

  a_r7_pop_final: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> last);

  a_r8_wr_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  a_r9_push_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    txPush |=> !txPush);

  a_r9_strobe_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn || txPush) |-> (!busy && $past(last)));

endmodule

bind slave_bus_ctrl slvbus_checker chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .csN         (csN),
  .fdsN        (fdsN),
  .cycleLenSel (cycleLenSel),
  .busy        (strb.active),
  .last        (strb.last),
  .dataValid   (dataValid),
  .rxPop       (rxPop),
  .txPush      (txPush),
  .regWrEn     (regWrEn)
);

// File: tb/slave_bus_ctrl_tb.sv
`timescale 1ns/1ps
module slave_bus_ctrl_tb_top;

  localparam int K_READ  = 0;
  localparam int K_POP   = 1;
  localparam int K_REGWR = 2;
  localparam int K_TX    = 3;

  typedef struct {
    int          kind;
    logic [31:0] val;
    string       tag;
  } sbItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, fdsN = 1'b1, rdWr = 1'b1;
  logic [4:0]  addr = '0;
  logic [1:0]  byteEn = '0;
  logic        cycleLenSel = 1'b1, swapBytes = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        dataValid;
  logic [4:0]  regAddr;
  logic [7:0]  regRdData;
  logic        regWrEn;
  logic [7:0]  regWrData;
  logic [15:0] rxData;
  logic        rxPop, txPush;
  logic [15:0] txData;
  logic [1:0]  txByteEn;

  int checks = 0;
  int errors = 0;
  sbItem_t expQ[$];
  int rxExpCnt = 0;
  logic [15:0] rxHwCnt;

  always #2 clk = ~clk;

  function automatic logic [7:0] regFn(input logic [4:0] a);
    return {3'b101, a} ^ 8'h3C;
  endfunction

  function automatic logic [15:0] rxFn(input int n);
    return 16'h1234 + 16'(n) * 16'h0101;
  endfunction

  // external register file and receive FIFO models
  assign regRdData = regFn(regAddr);
  assign rxData    = rxFn(int'(rxHwCnt));
  always_ff @(posedge clk) begin
    if (!rstN) rxHwCnt <= '0;
    else if (rxPop) rxHwCnt <= rxHwCnt + 16'd1;
  end

  slave_bus_ctrl dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .fdsN(fdsN), .rdWr(rdWr),
    .addr(addr), .byteEn(byteEn), .cycleLenSel(cycleLenSel),
    .swapBytes(swapBytes), .wrData(wrData), .rdData(rdData),
    .dataValid(dataValid), .regAddr(regAddr), .regRdData(regRdData),
    .regWrEn(regWrEn), .regWrData(regWrData), .rxData(rxData),
    .rxPop(rxPop), .txPush(txPush), .txData(txData), .txByteEn(txByteEn)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushExp(input int kind, input logic [31:0] val, input string tag);
    sbItem_t it;
    it.kind = kind; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic compareEvt(input int kind, input logic [31:0] val);
    sbItem_t it;
    if (expQ.size() == 0) begin
      check(1'b0, $sformatf("unexpected event kind %0d", kind), val, 32'h0);
    end else begin
      it = expQ.pop_front();
      check(it.kind == kind && it.val == val,
            $sformatf("%s kind %0d/%0d", it.tag, kind, it.kind), val, it.val);
    end
  endtask

  // monitor: sample away from the active edge
  int vCnt = 0;
  logic [15:0] lastRd = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (!dataValid)
          check(rdData == 16'h0, "R4 rdData zero when not valid", {16'h0, rdData}, 32'h0);
        if (rxPop) compareEvt(K_POP, 32'h0);
        if (dataValid) begin
          vCnt++;
          lastRd = rdData;
        end else if (vCnt != 0) begin
          compareEvt(K_READ, {16'(vCnt), lastRd});
          vCnt = 0;
        end
        if (regWrEn) compareEvt(K_REGWR, {19'h0, regAddr, regWrData});
        if (txPush)  compareEvt(K_TX, {14'h0, txByteEn, txData});
      end
    end
  end

  // driver: predicts the outcome, then runs one bus cycle
  task automatic busCycle(input bit useCs, input bit useFds, input bit rd,
                          input logic [4:0] a, input logic [1:0] be,
                          input bit tc, input bit flipTc, input bit sw,
                          input logic [15:0] wd, input string tag);
    bit cancel = useCs && useFds;
    bit rxRd   = rd && (useFds || a == 5'd0);
    bit txWr   = !rd && (useFds || a == 5'd1);
    bit regRd  = rd && !rxRd;
    bit regWr  = !rd && !useFds && a != 5'd0 && a != 5'd1;
    int len    = tc ? 2 : 3;
    logic [15:0] w;
    logic [7:0]  rb;
    if (!cancel) begin
      if (rxRd) begin
        w = rxFn(rxExpCnt);
        rxExpCnt++;
        pushExp(K_POP, 32'h0, {tag, " R7 pop"});
        if (be == 2'b01)      w = {w[7:0], w[7:0]};
        else if (be == 2'b10) w = {w[15:8], w[15:8]};
        pushExp(K_READ, {16'(len), w}, {tag, " R6 rx read"});
      end else if (regRd) begin
        rb = regFn(a);
        pushExp(K_READ, {16'(len), (sw ? {rb, 8'h00} : {8'h00, rb})},
                {tag, " R5 reg read"});
      end else if (regWr) begin
        pushExp(K_REGWR, {19'h0, a, (sw ? wd[15:8] : wd[7:0])}, {tag, " R8 reg write"});
      end else if (txWr) begin
        pushExp(K_TX, {14'h0, be, wd}, {tag, " R9 tx push"});
      end
    end
    csN = !useCs; fdsN = !useFds; rdWr = rd; addr = a; byteEn = be;
    cycleLenSel = tc; swapBytes = sw; wrData = wd;
    @(negedge clk);
    csN = 1'b1; fdsN = 1'b1; addr = ~a; byteEn = ~be;
    if (flipTc) cycleLenSel = ~tc;
    if (cancel) begin
      check(dataValid == 1'b0, {tag, " R2 no valid after both selects"},
            {31'h0, dataValid}, 32'h0);
    end else begin
      if (len == 3) @(negedge clk);
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    check(dataValid == 1'b0 && rdData == 16'h0 && !rxPop && !txPush && !regWrEn,
          "R12 reset state", {11'h0, dataValid, rxPop, txPush, regWrEn, rdData}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // register reads at both lengths and lanes (R1 R3 R5)
    busCycle(1, 0, 1, 5'd5,  2'b11, 1, 0, 0, 16'h0, "R1 R3 short");
    busCycle(1, 0, 1, 5'd9,  2'b11, 0, 0, 0, 16'h0, "R3 long");
    busCycle(1, 0, 1, 5'd17, 2'b11, 1, 0, 1, 16'h0, "R5 swap");
    busCycle(1, 0, 1, 5'd31, 2'b01, 0, 0, 1, 16'h0, "R5 swap long");
    // mid-cycle length change ignored (R3)
    busCycle(1, 0, 1, 5'd3,  2'b11, 1, 1, 0, 16'h0, "R3 flip short");
    busCycle(1, 0, 1, 5'd4,  2'b11, 0, 1, 0, 16'h0, "R3 flip long");
    // receive reads: word and byte lanes, both selects (R6 R7)
    busCycle(0, 1, 1, 5'd22, 2'b11, 1, 0, 0, 16'h0, "R6 fds word");
    busCycle(0, 1, 1, 5'd7,  2'b01, 1, 0, 0, 16'h0, "R6 fds low byte");
    busCycle(0, 1, 1, 5'd0,  2'b10, 0, 0, 0, 16'h0, "R6 fds high byte");
    busCycle(1, 0, 1, 5'd0,  2'b00, 1, 0, 1, 16'h0, "R6 cs rx word");
    busCycle(1, 0, 1, 5'd0,  2'b10, 0, 0, 0, 16'h0, "R6 cs rx high byte");
    // register writes, both lanes (R8)
    busCycle(1, 0, 0, 5'd12, 2'b01, 1, 0, 0, 16'hBEEF, "R8 low lane");
    busCycle(1, 0, 0, 5'd27, 2'b10, 0, 0, 1, 16'hC0DE, "R8 high lane");
    // transmit pushes (R9)
    busCycle(0, 1, 0, 5'd12, 2'b10, 1, 0, 0, 16'h5A01, "R9 fds byte");
    busCycle(1, 0, 0, 5'd1,  2'b11, 0, 0, 0, 16'h7E42, "R9 cs tx word");
    // cancelled cycles and ignored write (R2 R10)
    busCycle(1, 1, 1, 5'd5,  2'b11, 1, 0, 0, 16'h0, "R2 cancel read");
    busCycle(1, 1, 0, 5'd9,  2'b11, 0, 0, 0, 16'h1111, "R2 cancel write");
    busCycle(1, 0, 0, 5'd0,  2'b11, 1, 0, 0, 16'h2222, "R10 cs write rx loc");
    // back-to-back burst with changing lengths (R11)
    busCycle(0, 1, 1, 5'd0,  2'b11, 0, 0, 0, 16'h0, "R11 burst a");
    busCycle(1, 0, 1, 5'd6,  2'b11, 1, 0, 0, 16'h0, "R11 burst b");
    busCycle(0, 1, 0, 5'd6,  2'b01, 0, 0, 0, 16'h3C3C, "R11 burst c");
    busCycle(1, 0, 1, 5'd8,  2'b11, 1, 0, 1, 16'h0, "R11 burst d");
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R1 all expected events seen", 32'(expQ.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule